// File: doc/BRIEF.md
# Timer-Paced Single-Channel DMA Engine

This block is one DMA channel. It copies data units from a peripheral data register into memory, one unit for each request. A request comes either from one of several hardware request lines (normally a timer tick) or from a software trigger bit. Software programs the channel through a small word-addressed register port. It sets a source address, a destination address, an address mode for each side, a control word and a mask/trigger word. The channel then moves data through two simple valid/ready master ports: one reads the source and one writes the destination.

Each request moves exactly one unit. The source is usually a fixed peripheral register and the destination an incrementing buffer. After each completed unit, the remaining count drops by one. When the count runs out, the channel does one of two things. With reload disabled, it switches itself off. With reload enabled, it restores the programmed count and base addresses and stays on. In both cases it can pulse a terminal-count interrupt. The handshake-mode, request-sync, burst and whole-service bits of the control word are stored and read back, but they do not change the one-unit-per-request behaviour.

Top module: `hw_dma_channel`

## Requirements
- R1: After reset, every readable register (offsets 0 to 6) reads 0, no read or write is requested and the interrupt output is low.
- R2: With control bit 23 = 1 (hardware requests), a one-cycle high on request line `hw_req_i[n]` starts one unit, where n is control bits 26:24. Pulses on any other line start nothing.
- R3: A unit is one read at the current source address, followed by one write of exactly the read data to the current destination address. Each valid, with its address and data, holds until its ready is seen.
- R4: Address-mode bit 0 (offset 1 for the source, offset 3 for the destination) keeps that address fixed when 1 and advances it by the unit size after each unit when 0. Control bits 21:20 give the size: 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes. The size is driven on `unit_size_o`.
- R5: Writing the control word (offset 4) loads the remaining count from bits 19:0. The count drops by one per completed unit and reads back at offset 6.
- R6: A request that arrives while a unit is in flight is held, and one more unit runs once the current one completes.
- R7: With control bit 22 = 1 (no reload), completing the last unit clears the channel-on bit. When control bit 29 = 1, `tc_irq_o` is high for exactly one cycle, in the cycle after the final write handshake.
- R8: With control bit 22 = 0, completing the last unit reloads the programmed count and both base addresses, and the channel stays on.
- R9: In the mask/trigger word (offset 5), bit 1 turns the channel on and bit 2 stops it, with bit 2 taking priority. Bit 0 is a software trigger that counts only when control bit 23 = 0. Requests that arrive while the channel is off are dropped. Bit 1 of offset 5 reads back as the on state.
- R10: With control bit 29 = 0, the terminal count raises no interrupt.
- R11: Offsets 0 and 2 read back the current source and destination addresses. A write to either sets both the base and the current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register word offset |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data (combinational on cfg_addr_i) |
| hw_req_i | input | NUM_REQ | Hardware request lines, one pulse per request |
| rd_valid_o | output | 1 | Source read request |
| rd_addr_o | output | ADDR_W | Source read address |
| rd_ready_i | input | 1 | Source read accepted, data valid |
| rd_data_i | input | DATA_W | Source read data |
| wr_valid_o | output | 1 | Destination write request |
| wr_addr_o | output | ADDR_W | Destination write address |
| wr_data_o | output | DATA_W | Destination write data |
| wr_ready_i | input | 1 | Destination write accepted |
| unit_size_o | output | 2 | Unit size code of the current transfer |
| tc_irq_o | output | 1 | Terminal-count interrupt pulse |

## Verification
The bench targets four things. First, requests that arrive mid-unit: a design that drops them would stall short of the count. Second, the final unit: an off-by-one in the count would end one write early or late, or leave the channel on. Third, reload wrap-around: a design that fails to restore the base addresses would keep writing past the buffer. Fourth, the interrupt pulse, whose cycle and width are both checked. It also pulses the wrong request line, triggers while the channel is off, and uses the software trigger in hardware mode; a design that leaks any of these would show an unexpected read. Fixed and incrementing sources, all three unit sizes and randomly stalled ready signals catch address steps that are wrong, and data or addresses that change before their handshake.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam logic [2:0] OFS_SRC     = 3'd0;
  localparam logic [2:0] OFS_SRC_CTL = 3'd1;
  localparam logic [2:0] OFS_DST     = 3'd2;
  localparam logic [2:0] OFS_DST_CTL = 3'd3;
  localparam logic [2:0] OFS_CTRL    = 3'd4;
  localparam logic [2:0] OFS_MASK    = 3'd5;
  localparam logic [2:0] OFS_CNT     = 3'd6;

  localparam int B_IRQ_EN  = 29;
  localparam int B_SEL_LO  = 24;
  localparam int B_HW_SRC  = 23;
  localparam int B_NO_RLD  = 22;
  localparam int B_SIZE_LO = 20;

  localparam int M_STOP = 2;
  localparam int M_ON   = 1;
  localparam int M_TRIG = 0;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} xfer_st_e;

  function automatic logic [3:0] unit_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 4'd1;
      2'd1:    return 4'd2;
      default: return 4'd4;
    endcase
  endfunction
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic              unit_done_i,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic [ADDR_W-1:0] dst_addr_o,
  output logic [31:0]       ctrl_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              ch_on_o,
  output logic              sw_trig_o,
  output logic              tc_irq_o
);
  logic [ADDR_W-1:0] src_base_q, src_cur_q, dst_base_q, dst_cur_q;
  logic [1:0]        src_ctl_q, dst_ctl_q;
  logic [31:0]       ctrl_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              on_q, irq_q;
  logic              last_unit;
  logic [ADDR_W-1:0] step;

  assign last_unit = unit_done_i && (cnt_q == CNT_W'(1));
  assign step      = ADDR_W'(unit_bytes(ctrl_q[B_SIZE_LO+:2]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_base_q <= '0; src_cur_q <= '0; dst_base_q <= '0; dst_cur_q <= '0;
      src_ctl_q  <= '0; dst_ctl_q <= '0; ctrl_q <= '0; cnt_q <= '0;
      on_q       <= 1'b0; irq_q <= 1'b0;
    end else begin
      irq_q <= last_unit && ctrl_q[B_IRQ_EN];
      if (unit_done_i) begin
        if (last_unit && !ctrl_q[B_NO_RLD]) begin
          cnt_q     <= ctrl_q[CNT_W-1:0];
          src_cur_q <= src_base_q;
          dst_cur_q <= dst_base_q;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
          if (!src_ctl_q[0]) src_cur_q <= src_cur_q + step;
          if (!dst_ctl_q[0]) dst_cur_q <= dst_cur_q + step;
          if (last_unit) on_q <= 1'b0;
        end
      end
      // register writes take priority over same-cycle unit updates
      if (cfg_we_i) begin
        case (cfg_addr_i)
          OFS_SRC:     begin src_base_q <= ADDR_W'(cfg_wdata_i); src_cur_q <= ADDR_W'(cfg_wdata_i); end
          OFS_SRC_CTL: src_ctl_q <= cfg_wdata_i[1:0];
          OFS_DST:     begin dst_base_q <= ADDR_W'(cfg_wdata_i); dst_cur_q <= ADDR_W'(cfg_wdata_i); end
          OFS_DST_CTL: dst_ctl_q <= cfg_wdata_i[1:0];
          OFS_CTRL:    begin ctrl_q <= cfg_wdata_i; cnt_q <= cfg_wdata_i[CNT_W-1:0]; end
          OFS_MASK:    on_q <= cfg_wdata_i[M_ON] & ~cfg_wdata_i[M_STOP];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (cfg_addr_i)
      OFS_SRC:     cfg_rdata_o = 32'(src_cur_q);
      OFS_SRC_CTL: cfg_rdata_o = {30'd0, src_ctl_q};
      OFS_DST:     cfg_rdata_o = 32'(dst_cur_q);
      OFS_DST_CTL: cfg_rdata_o = {30'd0, dst_ctl_q};
      OFS_CTRL:    cfg_rdata_o = ctrl_q;
      OFS_MASK:    cfg_rdata_o = {30'd0, on_q, 1'b0};
      OFS_CNT:     cfg_rdata_o = 32'(cnt_q);
      default:     cfg_rdata_o = '0;
    endcase
  end

  assign src_addr_o = src_cur_q;
  assign dst_addr_o = dst_cur_q;
  assign ctrl_o     = ctrl_q;
  assign cnt_o      = cnt_q;
  assign ch_on_o    = on_q;
  assign tc_irq_o   = irq_q;
  assign sw_trig_o  = cfg_we_i && (cfg_addr_i == OFS_MASK) && cfg_wdata_i[M_TRIG];

  assert_cnt_dec_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unit_done_i && cnt_q > CNT_W'(1) && !cfg_we_i) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  assert_off_at_tc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_unit && ctrl_q[B_NO_RLD] && !cfg_we_i) |=> !on_q);
  assert_irq_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
  assert_stay_on_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_unit && !ctrl_q[B_NO_RLD] && on_q && !cfg_we_i) |=> (on_q && cnt_q == ctrl_q[CNT_W-1:0]));
endmodule

// File: rtl/dma_chan_req.sv
module dma_chan_req #(
  parameter int NUM_REQ = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] hw_req_i,
  input  logic [2:0]         sel_i,
  input  logic               hw_mode_i,
  input  logic               sw_trig_i,
  input  logic               ch_on_i,
  input  logic               cnt_nz_i,
  input  logic               busy_i,
  output logic               start_o
);
  logic hw_hit, hit, pend_q;

  always_comb begin
    hw_hit = 1'b0;
    for (int i = 0; i < NUM_REQ; i++)
      if (sel_i == 3'(i)) hw_hit = hw_req_i[i];
  end

  assign hit     = hw_mode_i ? hw_hit : sw_trig_i;
  assign start_o = pend_q && !busy_i && ch_on_i && cnt_nz_i;

  // one-deep hold: a new hit on the start cycle keeps the flag set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= 1'b0;
    else if (!ch_on_i) pend_q <= 1'b0;
    else if (hit)      pend_q <= 1'b1;
    else if (start_o)  pend_q <= 1'b0;
  end

  assert_req_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && ch_on_i) |=> pend_q);
  assert_off_drops_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ch_on_i |=> !pend_q);
endmodule

// File: rtl/dma_chan_xfer.sv
module dma_chan_xfer
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  output logic              rd_valid_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ready_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              wr_ready_i,
  output logic              busy_o,
  output logic              unit_done_o
);
  xfer_st_e          st_q;
  logic [ADDR_W-1:0] rd_a_q, wr_a_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; rd_a_q <= '0; wr_a_q <= '0; data_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q <= ST_RD; rd_a_q <= src_addr_i; wr_a_q <= dst_addr_i;
        end
        ST_RD: if (rd_ready_i) begin
          st_q <= ST_WR; data_q <= rd_data_i;
        end
        ST_WR: if (wr_ready_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_valid_o  = (st_q == ST_RD);
  assign wr_valid_o  = (st_q == ST_WR);
  assign rd_addr_o   = rd_a_q;
  assign wr_addr_o   = wr_a_q;
  assign wr_data_o   = data_q;
  assign busy_o      = (st_q != ST_IDLE);
  assign unit_done_o = (st_q == ST_WR) && wr_ready_i;

  assert_rd_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_addr_o)));
  assert_wr_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));
  assert_rd_then_wr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && rd_ready_i) |=> (wr_valid_o && wr_data_o == $past(rd_data_i)));
endmodule

// File: rtl/hw_dma_channel.sv
module hw_dma_channel
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 20,
  parameter int NUM_REQ = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [2:0]         cfg_addr_i,
  input  logic [31:0]        cfg_wdata_i,
  output logic [31:0]        cfg_rdata_o,
  input  logic [NUM_REQ-1:0] hw_req_i,
  output logic               rd_valid_o,
  output logic [ADDR_W-1:0]  rd_addr_o,
  input  logic               rd_ready_i,
  input  logic [DATA_W-1:0]  rd_data_i,
  output logic               wr_valid_o,
  output logic [ADDR_W-1:0]  wr_addr_o,
  output logic [DATA_W-1:0]  wr_data_o,
  input  logic               wr_ready_i,
  output logic [1:0]         unit_size_o,
  output logic               tc_irq_o
);
  logic [ADDR_W-1:0] src_addr, dst_addr;
  logic [31:0]       ctrl;
  logic [CNT_W-1:0]  cnt;
  logic              ch_on, sw_trig, start, busy, unit_done;

  dma_chan_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i, .cfg_rdata_o,
    .unit_done_i(unit_done), .src_addr_o(src_addr), .dst_addr_o(dst_addr),
    .ctrl_o(ctrl), .cnt_o(cnt), .ch_on_o(ch_on), .sw_trig_o(sw_trig), .tc_irq_o
  );

  dma_chan_req #(.NUM_REQ(NUM_REQ)) u_req (
    .clk_i, .rst_ni, .hw_req_i, .sel_i(ctrl[B_SEL_LO+:3]), .hw_mode_i(ctrl[B_HW_SRC]),
    .sw_trig_i(sw_trig), .ch_on_i(ch_on), .cnt_nz_i(|cnt), .busy_i(busy), .start_o(start)
  );

  dma_chan_xfer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_xfer (
    .clk_i, .rst_ni, .start_i(start), .src_addr_i(src_addr), .dst_addr_i(dst_addr),
    .rd_valid_o, .rd_addr_o, .rd_ready_i, .rd_data_i,
    .wr_valid_o, .wr_addr_o, .wr_data_o, .wr_ready_i,
    .busy_o(busy), .unit_done_o(unit_done)
  );

  assign unit_size_o = ctrl[B_SIZE_LO+:2];

  assert_start_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |-> (!rd_valid_o && !wr_valid_o));
  assert_start_rd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (rd_valid_o && rd_addr_o == $past(src_addr)));
endmodule

// File: tb/hw_dma_channel_tb_top.sv
module hw_dma_channel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_SRC = 0, A_SCTL = 1, A_DST = 2, A_DCTL = 3,
                         A_CTRL = 4, A_MASK = 5, A_CNT = 6;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic [7:0]  hw_req = '0;
  logic        rd_valid, rd_ready = 1'b0, wr_valid, wr_ready = 1'b0, irq;
  logic [31:0] rd_addr, rd_data = '0, wr_addr, wr_data;
  logic [1:0]  usize;

  int n_chk = 0, n_bad = 0;
  int n_rd = 0, n_wr = 0, n_irq = 0, cyc = 0, last_irq_cyc = 0;
  logic [31:0] rd_a_log [0:255];
  logic [31:0] rd_d_log [0:255];
  logic [31:0] wr_a_log [0:255];
  logic [31:0] wr_d_log [0:255];
  logic [1:0]  wr_s_log [0:255];
  int          wr_c_log [0:255];

  always #(CLK_PERIOD/2) clk = ~clk;

  hw_dma_channel dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .hw_req_i(hw_req),
    .rd_valid_o(rd_valid), .rd_addr_o(rd_addr), .rd_ready_i(rd_ready), .rd_data_i(rd_data),
    .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_ready_i(wr_ready),
    .unit_size_o(usize), .tc_irq_o(irq)
  );

  // memory-side model: random ready, logs each handshake due at the next edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      rd_ready = ($urandom % 4) != 0;
      rd_data  = $urandom;
      if (rd_valid && rd_ready) begin
        rd_a_log[n_rd & 255] = rd_addr; rd_d_log[n_rd & 255] = rd_data; n_rd++;
      end
      wr_ready = ($urandom % 4) != 0;
      if (wr_valid && wr_ready) begin
        wr_a_log[n_wr & 255] = wr_addr; wr_d_log[n_wr & 255] = wr_data;
        wr_s_log[n_wr & 255] = usize;   wr_c_log[n_wr & 255] = cyc; n_wr++;
      end
      if (irq) begin n_irq++; last_irq_cyc = cyc; end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a; #1; d = cfg_rdata;
  endtask

  task automatic pulse(input int line);
    @(negedge clk); hw_req[line] = 1'b1;
    @(negedge clk); hw_req = '0;
  endtask

  function automatic logic [31:0] step_of(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
  endfunction

  function automatic logic [31:0] mk_ctrl(input bit irq_en, input bit hw, input bit no_rld,
                                          input logic [1:0] sz, input int cnt);
    return (32'd1 << 31) | (32'(irq_en) << 29) | (32'd3 << 24) | (32'(hw) << 23) |
           (32'(no_rld) << 22) | (32'(sz) << 20) | 32'(cnt);
  endfunction

  task automatic wait_rd(input int target);
    int t = 0;
    while (n_rd < target && t < 3000) begin @(negedge clk); t++; end
    if (n_rd < target) chk("R6 request lost, read count", 32'(n_rd), 32'(target));
  endtask

  task automatic wait_wr(input int target);
    int t = 0;
    while (n_wr < target && t < 3000) begin @(negedge clk); t++; end
    if (n_wr < target) chk("R6 units stalled, write count", 32'(n_wr), 32'(target));
  endtask

  // one request per unit; next request may land while the previous unit is in flight
  task automatic issue_units(input int n, input int b_rd);
    for (int u = 0; u < n; u++) begin
      pulse(3);
      wait_rd(b_rd + u + 1);
      repeat ($urandom % 4) @(negedge clk);
    end
  endtask

  task automatic run_job(input logic [31:0] src, input bit src_fix, input logic [31:0] dst,
                         input logic [1:0] sz, input int cnt, input bit irq_en);
    int b_rd = n_rd, b_wr = n_wr, b_irq = n_irq;
    logic [31:0] st = step_of(sz), d;
    cfg_write(A_SRC, src);
    cfg_write(A_SCTL, {30'd0, 1'b1, src_fix});
    cfg_write(A_DST, dst);
    cfg_write(A_DCTL, 32'd0);
    cfg_write(A_CTRL, mk_ctrl(irq_en, 1'b1, 1'b1, sz, cnt));
    cfg_write(A_MASK, 32'h2);
    issue_units(cnt, b_rd);
    wait_wr(b_wr + cnt);
    repeat (4) @(negedge clk);
    for (int k = 0; k < cnt; k++) begin
      chk("R4 dst address", wr_a_log[(b_wr+k) & 255], dst + 32'(k) * st);
      chk("R3 write data", wr_d_log[(b_wr+k) & 255], rd_d_log[(b_rd+k) & 255]);
      chk("R4 src address", rd_a_log[(b_rd+k) & 255], src_fix ? src : src + 32'(k) * st);
      chk("R4 unit size", 32'(wr_s_log[(b_wr+k) & 255]), 32'(sz));
    end
    cfg_read(A_CNT, d);  chk("R5 count at end", d, 32'd0);
    cfg_read(A_MASK, d); chk("R7 channel off", d, 32'd0);
    cfg_read(A_DST, d);  chk("R11 dst readback", d, dst + 32'(cnt) * st);
    chk(irq_en ? "R7 irq pulses" : "R10 irq pulses", 32'(n_irq - b_irq), irq_en ? 32'd1 : 32'd0);
    if (irq_en) chk("R7 irq timing", 32'(last_irq_cyc), 32'(wr_c_log[(b_wr+cnt-1) & 255] + 1));
  endtask

  initial begin
    logic [31:0] d;
    int b_rd, b_wr, b_irq;
    void'($urandom(32'd7391));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 rd_valid", 32'(rd_valid), 32'd0);
    chk("R1 wr_valid", 32'(wr_valid), 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);
    for (int a = 0; a < 7; a++) begin
      cfg_addr = 3'(a); #1;
      chk("R1 register reset value", cfg_rdata, 32'd0);
    end
    @(negedge clk); rst_n = 1'b1;

    // R9: requests while off are dropped
    cfg_write(A_SRC, 32'h4000_000c); cfg_write(A_SCTL, 32'h3);
    cfg_write(A_DST, 32'h2000_0000); cfg_write(A_DCTL, 32'h0);
    cfg_write(A_CTRL, mk_ctrl(1'b1, 1'b1, 1'b1, 2'd2, 4));
    b_rd = n_rd;
    pulse(3); repeat (10) @(negedge clk);
    chk("R9 request while off", 32'(n_rd - b_rd), 32'd0);
    cfg_read(A_CNT, d); chk("R5 count loaded", d, 32'd4);
    // R2: wrong line ignored
    cfg_write(A_MASK, 32'h2);
    pulse(5); repeat (10) @(negedge clk);
    chk("R2 other line ignored", 32'(n_rd - b_rd), 32'd0);
    // R9: software trigger ignored in hardware mode
    cfg_write(A_MASK, 32'h3); repeat (10) @(negedge clk);
    chk("R9 sw trigger in hw mode", 32'(n_rd - b_rd), 32'd0);
    cfg_read(A_CNT, d); chk("R9 count untouched", d, 32'd4);
    // R9: stop wins over on
    cfg_write(A_MASK, 32'h6);
    cfg_read(A_MASK, d); chk("R9 stop priority", d, 32'd0);

    // R9/R5: software mode, mid-count readback
    b_wr = n_wr;
    cfg_write(A_CTRL, mk_ctrl(1'b0, 1'b0, 1'b1, 2'd2, 2));
    cfg_write(A_MASK, 32'h2);
    cfg_write(A_MASK, 32'h3);
    wait_wr(b_wr + 1); repeat (3) @(negedge clk);
    cfg_read(A_CNT, d); chk("R5 count after one unit", d, 32'd1);
    cfg_read(A_MASK, d); chk("R9 on readback", d, 32'h2);
    cfg_write(A_MASK, 32'h3);
    wait_wr(b_wr + 2); repeat (3) @(negedge clk);
    cfg_read(A_CNT, d); chk("R5 count at zero", d, 32'd0);
    cfg_read(A_MASK, d); chk("R7 off after last", d, 32'd0);
    chk("R9 sw dst step", wr_a_log[(b_wr+1) & 255], 32'h2000_0004);

    // R8: reload wraps addresses, stays on, interrupts each pass
    b_rd = n_rd; b_wr = n_wr; b_irq = n_irq;
    cfg_write(A_DST, 32'h3000_0100);
    cfg_write(A_CTRL, mk_ctrl(1'b1, 1'b1, 1'b0, 2'd2, 3));
    cfg_write(A_MASK, 32'h2);
    issue_units(6, b_rd);
    wait_wr(b_wr + 6); repeat (4) @(negedge clk);
    for (int k = 0; k < 6; k++)
      chk("R8 reload address", wr_a_log[(b_wr+k) & 255], 32'h3000_0100 + 32'(k % 3) * 4);
    chk("R8 irq per pass", 32'(n_irq - b_irq), 32'd2);
    cfg_read(A_MASK, d); chk("R8 stays on", d, 32'h2);
    cfg_read(A_CNT, d);  chk("R8 count reloaded", d, 32'd3);
    cfg_write(A_MASK, 32'h4);

    // directed corners then random jobs
    run_job(32'h4000_000c, 1'b1, 32'h1000_0000, 2'd2, 1, 1'b1);
    run_job(32'h4000_0000, 1'b0, 32'h1000_0200, 2'd0, 5, 1'b0);
    for (int j = 0; j < 10; j++)
      run_job($urandom & 32'hffff_fffc, 1'($urandom % 2), 32'h1000_0000 + ($urandom % 256) * 16,
              2'($urandom % 3), 1 + int'($urandom % 8), 1'($urandom % 2));

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R6 watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule